// File: doc/BRIEF.md
# Serial Command Receiver with Mute-Guarded Settings

This block receives 12-bit command words from a host over three wires: a serial clock, a data line and an enable line. The clock and enable lines rest high. The host pulls enable low, presents one bit per serial clock rising edge, and raises enable again. That rising edge hands the collected word to the block for evaluation. All three lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and every edge is detected in the system clock domain.

A word carries a 3-bit delay-time selector, a mute control bit and a rate bit. The rate bit picks between a fast rate, with delay steps of `STEP_MS`, and a slow rate with twice that step. The block holds the audio path muted until the host has completed a start-up handshake: a word that releases mute, then a word that engages it. After that, delay and rate can change only inside a bracket. The host first sends the new setting with mute engaged. It then sends the identical setting with mute released. Closing the bracket applies the setting, releases mute and pulses a one-cycle memory-initialisation request. Words with the wrong number of clock edges, words that arrive too soon after the previous one, and words that break the rules are discarded. Two flags report the outcome of the most recent word.

Top module: `serial_ctrl_reg`

## Requirements
- R1: After reset the outputs are as follows: `sys_mute_o`=1, `delay_code_o`=0, `slow_rate_o`=0, `delay_ms_o`=10, `mem_init_o`=0, `frame_err_o`=0 and `cmd_err_o`=0.
- R2: A data bit is taken on each serial clock rising edge while enable is low. The first bit taken becomes word bit 0. The word is evaluated on the enable rising edge. Serial clock edges while enable is high have no effect.
- R3: A word framed by anything other than exactly 12 serial clock rising edges is discarded. It sets `frame_err_o`=1 and `cmd_err_o`=0, and it leaves the settings and mute unchanged.
- R4: A word whose enable rising edge comes less than `MIN_GAP` system cycles after the previous enable rising edge is discarded and sets `frame_err_o`=1.
- R5: The delay code is {bit5, bit6, bit7}, with bit5 as the most significant bit. Bit 8 = 0 engages mute and bit 8 = 1 releases it. Bit 9 = 1 selects the slow rate. Bits 0-4, 10 and 11 are ignored.
- R6: `delay_ms_o` = (code+1)·10 at the fast rate and (code+1)·20 at the slow rate. A word carrying code 6 or 7 is rejected with `cmd_err_o`=1.
- R7: Before the start-up handshake, a mute-engage word is rejected with `cmd_err_o`=1. A mute-release word is accepted but keeps `sys_mute_o`=1.
- R8: A mute-engage word that follows the start-up mute-release word completes the handshake. It applies that word's delay and rate, and mute stays engaged.
- R9: When unmuted, a mute-engage word sets `sys_mute_o`=1 and leaves the applied delay and rate unchanged. A mute-release word with the applied fields is accepted with no change. A mute-release word with different fields is rejected with `cmd_err_o`=1.
- R10: When muted after the handshake, a mute-release word whose delay and rate equal the pending setting applies that setting, clears `sys_mute_o`, and raises `mem_init_o` for exactly one cycle.
- R11: When muted after the handshake, a mute-release word whose fields differ from the pending setting is rejected with `cmd_err_o`=1 and mute stays engaged.
- R12: When muted after the handshake, a further mute-engage word replaces the pending setting.
- R13: The applied delay code and rate change only in a cycle that follows a cycle with mute engaged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, idles high, asynchronous |
| ser_dat_i | input | 1 | Serial data, asynchronous |
| ser_en_i | input | 1 | Word enable, low while framing, idles high |
| delay_code_o | output | 3 | Applied delay selector |
| delay_ms_o | output | DMS_W | Applied delay in milliseconds |
| slow_rate_o | output | 1 | Applied rate, 1 = slow |
| sys_mute_o | output | 1 | System mute, 1 = muted |
| mem_init_o | output | 1 | One-cycle memory-initialisation request |
| frame_err_o | output | 1 | Last word discarded for count or spacing |
| cmd_err_o | output | 1 | Last word rejected by the command rules |

## Verification
On every cycle, assertions check the following:
- the bit counter stays bounded;
- the shift register holds while enable is high;
- the initialisation request lasts one cycle and coincides with an unmuted output;
- the applied code stays in the legal range;
- the applied fields change only after a muted cycle.

Only the bench's scenarios can show the rest: the start-up handshake order, bracket matching against the pending setting, replacement of that setting, rejection of short, long and early words, and the bit positions. These depend on a sequence of words, not on a single cycle. The bench sweeps every delay code at both rates through complete change brackets.

// File: rtl/scw_pkg.sv
package scw_pkg;
  // Bit positions that the command decoder relies on (bit 0 = first bit shifted in)
  localparam int BIT_DLY_HI  = 5;
  localparam int BIT_DLY_MID = 6;
  localparam int BIT_DLY_LO  = 7;
  localparam int BIT_MUTE    = 8;
  localparam int BIT_RATE    = 9;
  localparam logic [2:0] DLY_MAX = 3'd5;

  typedef enum logic [1:0] {
    ST_BOOT   = 2'd0,
    ST_ARMED  = 2'd1,
    ST_MUTED  = 2'd2,
    ST_ACTIVE = 2'd3
  } seq_st_e;

  typedef struct packed {
    logic [2:0] dly;
    logic       slow;
  } setting_t;
endpackage

// File: rtl/scw_sync.sv
module scw_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/scw_framer.sv
module scw_framer #(
  parameter int WORD_BITS = 12,
  parameter int MIN_GAP   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk_i,
  input  logic                 sdat_i,
  input  logic                 sen_i,
  output logic                 evt_o,
  output logic                 good_o,
  output logic [WORD_BITS-1:0] word_o
);
  localparam int CNT_W = $clog2(WORD_BITS + 2);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_BITS);
  localparam logic [GAP_W-1:0] GAP_SAT  = GAP_W'(MIN_GAP);

  logic                 sclk_q, sen_q;
  logic [WORD_BITS-1:0] sr_q, sr_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [GAP_W-1:0]     gap_q, gap_d;
  logic                 sclk_rise, sen_rise, sen_fall, sh_en;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign sen_rise  = sen_i & ~sen_q;
  assign sen_fall  = ~sen_i & sen_q;
  assign sh_en     = sclk_rise & ~sen_i & ~sen_fall;

  always_comb begin
    sr_d  = {sdat_i, sr_q[WORD_BITS-1:1]};
    cnt_d = cnt_q;
    if (sen_fall) begin
      cnt_d = '0;
    end else if (sh_en && (cnt_q != CNT_FULL)) begin
      cnt_d = cnt_q + 1'b1;
    end
    gap_d = gap_q;
    if (sen_rise) begin
      gap_d = '0;
    end else if (gap_q != GAP_SAT) begin
      gap_d = gap_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b1;
      sen_q  <= 1'b1;
      cnt_q  <= '0;
      gap_q  <= GAP_SAT;
    end else begin
      sclk_q <= sclk_i;
      sen_q  <= sen_i;
      cnt_q  <= cnt_d;
      gap_q  <= gap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (sh_en) begin
      sr_q <= sr_d;
    end
  end

  assign evt_o  = sen_rise;
  assign good_o = sen_rise & (cnt_q == CNT_WORD) & (gap_q == GAP_SAT);
  assign word_o = sr_q;

  // R3: the edge counter saturates one past a full word
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R2: nothing is shifted while enable rests high
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sen_i |=> $stable(sr_q));
endmodule

// File: rtl/scw_seq.sv
module scw_seq
  import scw_pkg::*;
#(
  parameter int WORD_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_i,
  input  logic                 good_i,
  input  logic [WORD_BITS-1:0] word_i,
  output logic [2:0]           dly_o,
  output logic                 slow_o,
  output logic                 mute_o,
  output logic                 init_o,
  output logic                 ferr_o,
  output logic                 cerr_o
);
  seq_st_e  st_q, st_d;
  setting_t cur_q, cur_d, pend_q, pend_d, w_set;
  logic     init_q, init_d, ferr_q, ferr_d, cerr_q, cerr_d;
  logic     w_unmute, w_legal, rej;

  assign w_set.dly  = {word_i[BIT_DLY_HI], word_i[BIT_DLY_MID], word_i[BIT_DLY_LO]};
  assign w_set.slow = word_i[BIT_RATE];
  assign w_unmute   = word_i[BIT_MUTE];
  assign w_legal    = (w_set.dly <= DLY_MAX);

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    pend_d = pend_q;
    ferr_d = ferr_q;
    cerr_d = cerr_q;
    init_d = 1'b0;
    rej    = 1'b0;
    if (evt_i) begin
      ferr_d = ~good_i;
      if (good_i) begin
        if (!w_legal) begin
          rej = 1'b1;
        end else begin
          unique case (st_q)
            ST_BOOT: begin
              if (w_unmute) st_d = ST_ARMED;
              else          rej  = 1'b1;
            end
            ST_ARMED: begin
              if (!w_unmute) begin
                st_d   = ST_MUTED;
                cur_d  = w_set;
                pend_d = w_set;
              end
            end
            ST_MUTED: begin
              if (!w_unmute) begin
                pend_d = w_set;
              end else if (w_set == pend_q) begin
                st_d   = ST_ACTIVE;
                cur_d  = w_set;
                init_d = 1'b1;
              end else begin
                rej = 1'b1;
              end
            end
            ST_ACTIVE: begin
              if (!w_unmute) begin
                st_d   = ST_MUTED;
                pend_d = w_set;
              end else if (w_set != cur_q) begin
                rej = 1'b1;
              end
            end
            default: st_d = ST_BOOT;
          endcase
        end
      end
      cerr_d = rej;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_BOOT;
      cur_q  <= '0;
      pend_q <= '0;
      init_q <= 1'b0;
      ferr_q <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      pend_q <= pend_d;
      init_q <= init_d;
      ferr_q <= ferr_d;
      cerr_q <= cerr_d;
    end
  end

  assign dly_o  = cur_q.dly;
  assign slow_o = cur_q.slow;
  assign mute_o = (st_q != ST_ACTIVE);
  assign init_o = init_q;
  assign ferr_o = ferr_q;
  assign cerr_o = cerr_q;

  // R10: initialisation request is a single-cycle pulse
  a_r10_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |=> !init_q);

  // R10: the request comes with mute released
  a_r10_init_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> !mute_o);

  // R6: only legal delay codes are ever applied
  a_r6_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cur_q.dly <= DLY_MAX);

  // R13: applied fields change only after a muted cycle
  a_r13_change_muted: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_q) |-> $past(mute_o));

  // R3: a discarded frame never also reports a command error
  a_r3_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q |-> !cerr_q);
endmodule

// File: rtl/serial_ctrl_reg.sv
module serial_ctrl_reg #(
  parameter int  WORD_BITS = 12,
  parameter int  MIN_GAP   = 64,
  parameter int  STEP_MS   = 10,
  localparam int DMS_W     = $clog2(12 * STEP_MS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk_i,
  input  logic             ser_dat_i,
  input  logic             ser_en_i,
  output logic [2:0]       delay_code_o,
  output logic [DMS_W-1:0] delay_ms_o,
  output logic             slow_rate_o,
  output logic             sys_mute_o,
  output logic             mem_init_o,
  output logic             frame_err_o,
  output logic             cmd_err_o
);
  logic                 rst_s1_q, rst_s2_q;
  logic [2:0]           ln_s;
  logic                 evt, good;
  logic [WORD_BITS-1:0] word;
  logic [DMS_W-1:0]     base_ms;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  scw_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk   (clk),
    .rst_n (rst_s2_q),
    .d_i   ({ser_en_i, ser_dat_i, ser_clk_i}),
    .q_o   (ln_s)
  );

  scw_framer #(.WORD_BITS(WORD_BITS), .MIN_GAP(MIN_GAP)) u_framer (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .sclk_i (ln_s[0]),
    .sdat_i (ln_s[1]),
    .sen_i  (ln_s[2]),
    .evt_o  (evt),
    .good_o (good),
    .word_o (word)
  );

  scw_seq #(.WORD_BITS(WORD_BITS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_s2_q),
    .evt_i  (evt),
    .good_i (good),
    .word_i (word),
    .dly_o  (delay_code_o),
    .slow_o (slow_rate_o),
    .mute_o (sys_mute_o),
    .init_o (mem_init_o),
    .ferr_o (frame_err_o),
    .cerr_o (cmd_err_o)
  );

  always_comb begin
    base_ms    = DMS_W'((int'(delay_code_o) + 1) * STEP_MS);
    delay_ms_o = slow_rate_o ? DMS_W'(base_ms << 1) : base_ms;
  end
endmodule

// File: tb/tb_serial_ctrl_reg.sv
module tb_serial_ctrl_reg;
  localparam int GAP  = 110;
  localparam int MING = 100;

  logic       clk, rst_n, ser_clk, ser_dat, ser_en;
  logic [2:0] delay_code;
  logic [6:0] delay_ms;
  logic       slow_rate, sys_mute, mem_init, frame_err, cmd_err;

  int tests = 0, fails = 0, init_cnt = 0, exp_init = 0;
  int cur_code = 0, cur_slow = 0;

  serial_ctrl_reg #(.WORD_BITS(12), .MIN_GAP(MING), .STEP_MS(10)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_en_i(ser_en), .delay_code_o(delay_code), .delay_ms_o(delay_ms),
    .slow_rate_o(slow_rate), .sys_mute_o(sys_mute), .mem_init_o(mem_init),
    .frame_err_o(frame_err), .cmd_err_o(cmd_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) if (mem_init) init_cnt <= init_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int code, input int slow, input int unmute, input int junk);
    logic [11:0] w;
    logic [7:0]  j;
    j = 8'(junk * 37 + 11);
    w = '0;
    w[4:0]   = j[4:0];
    w[5]     = code[2];
    w[6]     = code[1];
    w[7]     = code[0];
    w[8]     = unmute[0];
    w[9]     = slow[0];
    w[11:10] = j[6:5];
    return w;
  endfunction

  task automatic send(input logic [11:0] w, input int nclk, input int gap);
    @(negedge clk) ser_en = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      ser_dat = (i < 12) ? w[i] : 1'b0;
      ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
    end
    ser_en = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    ser_clk = 1'b1; ser_dat = 1'b1; ser_en = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 mute", sys_mute, 1);
    chk("R1 code", delay_code, 0);
    chk("R1 slow", slow_rate, 0);
    chk("R1 ms", delay_ms, 10);
    chk("R1 init", mem_init, 0);
    chk("R1 ferr", frame_err, 0);
    chk("R1 cerr", cmd_err, 0);

    // R7 mute-engage before handshake is rejected
    send(mk(2, 0, 0, 1), 12, GAP);
    chk("R7 early engage cerr", cmd_err, 1);
    chk("R7 early engage mute", sys_mute, 1);
    chk("R7 early engage code", delay_code, 0);
    // R7 mute-release accepted, still muted
    send(mk(3, 0, 1, 2), 12, GAP);
    chk("R7 release cerr", cmd_err, 0);
    chk("R7 release mute", sys_mute, 1);
    // R8 handshake completion applies fields
    send(mk(1, 1, 0, 3), 12, GAP);
    chk("R8 mute", sys_mute, 1);
    chk("R8 code", delay_code, 1);
    chk("R8 ms", delay_ms, 40);
    // R10 closing bracket
    send(mk(1, 1, 1, 4), 12, GAP);
    exp_init++;
    chk("R10 mute", sys_mute, 0);
    chk("R10 init count", init_cnt, exp_init);
    cur_code = 1; cur_slow = 1;

    // sweep all codes at both rates: R5 R6 R9 R10 R11
    for (int c = 0; c < 8; c++) begin
      for (int r = 0; r < 2; r++) begin
        send(mk(c, r, 0, c * 2 + r), 12, GAP);
        if (c > 5) begin
          chk("R6 illegal cerr", cmd_err, 1);
          chk("R6 illegal mute", sys_mute, 0);
          chk("R6 illegal code", delay_code, cur_code);
          continue;
        end
        chk("R9 engage mute", sys_mute, 1);
        chk("R9 engage code kept", delay_code, cur_code);
        chk("R9 engage rate kept", slow_rate, cur_slow);
        send(mk(c, 1 - r, 1, c + 5), 12, GAP);
        chk("R11 mismatch cerr", cmd_err, 1);
        chk("R11 mismatch mute", sys_mute, 1);
        send(mk(c, r, 1, c + 9), 12, GAP);
        exp_init++;
        cur_code = c; cur_slow = r;
        chk("R10 sweep mute", sys_mute, 0);
        chk("R5 sweep code", delay_code, c);
        chk("R5 sweep rate", slow_rate, r);
        chk("R6 sweep ms", delay_ms, (c + 1) * 10 * (r + 1));
        chk("R10 sweep init", init_cnt, exp_init);
      end
    end

    // R9 unmuted release words
    send(mk(2, 1, 1, 7), 12, GAP);
    chk("R9 diff release cerr", cmd_err, 1);
    chk("R9 diff release code", delay_code, cur_code);
    send(mk(cur_code, cur_slow, 1, 8), 12, GAP);
    chk("R9 same release cerr", cmd_err, 0);
    chk("R9 same release init", init_cnt, exp_init);

    // R12 pending replaced
    send(mk(2, 0, 0, 1), 12, GAP);
    send(mk(4, 0, 0, 2), 12, GAP);
    send(mk(2, 0, 1, 3), 12, GAP);
    chk("R12 old pending cerr", cmd_err, 1);
    chk("R12 old pending mute", sys_mute, 1);
    send(mk(4, 0, 1, 4), 12, GAP);
    exp_init++;
    cur_code = 4; cur_slow = 0;
    chk("R12 new pending code", delay_code, 4);
    chk("R12 new pending mute", sys_mute, 0);

    // R3 wrong edge counts
    send(mk(0, 0, 0, 5), 11, GAP);
    chk("R3 short ferr", frame_err, 1);
    chk("R3 short cerr", cmd_err, 0);
    chk("R3 short mute", sys_mute, 0);
    send(mk(0, 0, 0, 6), 13, GAP);
    chk("R3 long ferr", frame_err, 1);
    chk("R3 long mute", sys_mute, 0);
    send(mk(cur_code, cur_slow, 1, 7), 12, GAP);
    chk("R3 recover ferr", frame_err, 0);

    // R4 word too soon after the previous one
    send(mk(cur_code, cur_slow, 1, 8), 12, 2);
    send(mk(0, 0, 0, 9), 12, GAP);
    chk("R4 early ferr", frame_err, 1);
    chk("R4 early mute", sys_mute, 0);
    chk("R4 early code", delay_code, cur_code);

    // R2 clock edges with enable high are ignored
    for (int k = 0; k < 5; k++) begin
      ser_dat = 1'b1; ser_clk = 1'b0;
      repeat (2) @(negedge clk);
      ser_clk = 1'b1;
      repeat (2) @(negedge clk);
    end
    repeat (GAP) @(negedge clk);
    send(mk(3, 0, 0, 10), 12, GAP);
    chk("R2 idle edges ferr", frame_err, 0);
    chk("R2 idle edges mute", sys_mute, 1);
    send(mk(3, 0, 1, 11), 12, GAP);
    exp_init++;
    chk("R2 bit order code", delay_code, 3);
    chk("R2 bit order mute", sys_mute, 0);
    chk("R10 final init", init_cnt, exp_init);

    finish_run();
  end
endmodule